// File: doc/BRIEF.md
# Data-Triggered Micro-Thread Tensor Scheduler

This block shares one tensor datapath among several pending tensor operations, here called micro-threads. Each thread occupies one of up to eight slots. A slot's descriptor holds a start address, an address stride, an element count, a 2-bit priority and a trigger tag. A thread does not start when its descriptor is written. It starts when a data word carrying its tag arrives. From then on, the scheduler steps the thread one element at a time.

On every clock cycle the scheduler looks at the live readiness of each running thread. A thread is ready when its input operand is available and its destination has room. From the ready threads it picks one to issue. The highest priority wins. Ties are broken round-robin, starting after the thread that issued most recently. The issued slot number, element index, operand address and a last-element flag come out of registers one cycle later. The arithmetic is done elsewhere.

Top module: `mt_sched`

## Requirements
- R1: After synchronous reset every slot is free, `iss_valid` is 0 and the round-robin pointer rests on the highest slot number, so slot 0 is first in line among equals.
- R2: A descriptor write (`cfg_we`) is accepted only when the addressed slot is free and `cfg_len` is non-zero. Such a write arms the slot. A write to an armed or running slot, or one with zero length, is ignored.
- R3: A trigger (`trig_valid`) starts every armed slot whose stored tag equals `trig_tag`. A started slot can issue from the next cycle on. Triggers have no effect on free or running slots.
- R4: A running slot i is eligible in a cycle only when `in_avail[i]` and `out_room[i]` are both 1 in that cycle.
- R5: Among eligible slots, the one with the numerically largest 2-bit priority is issued.
- R6: Among eligible slots that share the top priority, the first one found counting upward (with wrap) from the slot after the most recently issued slot is chosen.
- R7: An issue decision made in cycle t appears on `iss_valid`, `iss_slot`, `iss_idx` and `iss_addr` after the clock edge that ends cycle t. Element k of a thread has address base + k*stride modulo 2^AW and index k, with k counting from 0.
- R8: The issue of element len-1 raises `iss_last`. That slot is free after the same edge, so a descriptor write in the following cycle is accepted. A write in the cycle of the final issue is ignored.
- R9: In a cycle with no eligible slot, `iss_valid` is 0 after the edge and no slot's index, address or state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_slot | input | SW | Slot addressed by the write |
| cfg_base | input | AW | Address of element 0 |
| cfg_stride | input | AW | Address step per element |
| cfg_len | input | LW | Element count (0 is rejected) |
| cfg_prio | input | 2 | Priority, larger wins |
| cfg_tag | input | TW | Tag that starts the thread |
| trig_valid | input | 1 | Tagged data word arrives |
| trig_tag | input | TW | Tag of the arriving word |
| in_avail | input | NT | Per-slot input operand available |
| out_room | input | NT | Per-slot destination can accept |
| iss_valid | output | 1 | An element step was issued |
| iss_slot | output | SW | Slot that issued |
| iss_idx | output | LW | Element index issued |
| iss_addr | output | AW | Operand address of that element |
| iss_last | output | 1 | Issued element is the thread's last |

## Verification
Two events can land on one slot in the same cycle: its final element issues and a new descriptor write addresses it. The same holds for a trigger arriving while the tagged thread is still running. The bench makes these collisions happen on purpose. It uses short lengths, few distinct tags and dense random writes and triggers, and it also runs a directed case that writes to a slot exactly on its last-issue cycle. A cycle-level reference model in the bench judges each collision. The write or trigger must be dropped, and any later addresses must come from the old descriptor. A fresh write one cycle later must be taken.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int PRIO_W = 2;
  localparam int PRIO_LEVELS = 1 << PRIO_W;

  typedef enum logic [1:0] {
    SL_FREE  = 2'd0,
    SL_ARMED = 2'd1,
    SL_RUN   = 2'd2
  } slot_st_e;
endpackage

// File: rtl/mt_slot.sv
module mt_slot
  import mt_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 8,
  parameter int TW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_hit,
  input  logic [AW-1:0]     cfg_base,
  input  logic [AW-1:0]     cfg_stride,
  input  logic [LW-1:0]     cfg_len,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic [TW-1:0]     cfg_tag,
  input  logic              trig_valid,
  input  logic [TW-1:0]     trig_tag,
  input  logic              issue_sel,
  output logic              running,
  output logic [PRIO_W-1:0] prio,
  output logic [AW-1:0]     cur_addr,
  output logic [LW-1:0]     cur_idx,
  output logic              is_last
);
  slot_st_e      st;
  logic [TW-1:0] tag;
  logic [LW-1:0] len;
  logic [AW-1:0] stride;

  assign running = (st == SL_RUN);
  assign is_last = (cur_idx == len - LW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SL_FREE;
      tag      <= '0;
      len      <= '0;
      stride   <= '0;
      prio     <= '0;
      cur_addr <= '0;
      cur_idx  <= '0;
    end else begin
      case (st)
        SL_FREE: if (cfg_hit && cfg_len != '0) begin
          st       <= SL_ARMED;
          tag      <= cfg_tag;
          len      <= cfg_len;
          stride   <= cfg_stride;
          prio     <= cfg_prio;
          cur_addr <= cfg_base;
          cur_idx  <= '0;
        end
        SL_ARMED: if (trig_valid && trig_tag == tag) st <= SL_RUN;
        SL_RUN: if (issue_sel) begin
          if (is_last) st <= SL_FREE;
          else begin
            cur_idx  <= cur_idx + LW'(1);
            cur_addr <= cur_addr + stride;
          end
        end
        default: st <= SL_FREE;
      endcase
    end
  end

  // R4
  grant_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    issue_sel |-> st == SL_RUN);

  // R9
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (st == SL_RUN && !issue_sel) |=> (st == SL_RUN && $stable(cur_idx) && $stable(cur_addr)));
endmodule

// File: rtl/mt_arbiter.sv
module mt_arbiter
  import mt_pkg::*;
#(
  parameter int NT = 8,
  localparam int SW = $clog2(NT)
) (
  input  logic [NT-1:0]        elig,
  input  logic [NT*PRIO_W-1:0] prio_flat,
  input  logic [SW-1:0]        rr_last,
  output logic [NT-1:0]        gnt,
  output logic [SW-1:0]        gnt_id,
  output logic                 any
);
  logic [PRIO_W-1:0] top_p;
  logic [NT-1:0]     cand;

  always_comb begin
    top_p = '0;
    for (int p = 0; p < PRIO_LEVELS; p++) begin
      for (int i = 0; i < NT; i++) begin
        if (elig[i] && prio_flat[i*PRIO_W +: PRIO_W] == PRIO_W'(p)) top_p = PRIO_W'(p);
      end
    end
    for (int i = 0; i < NT; i++)
      cand[i] = elig[i] && (prio_flat[i*PRIO_W +: PRIO_W] == top_p);
  end

  always_comb begin
    any    = 1'b0;
    gnt_id = '0;
    gnt    = '0;
    for (int k = 1; k <= NT; k++) begin
      int j;
      j = (int'(rr_last) + k) % NT;
      if (!any && cand[j]) begin
        any    = 1'b1;
        gnt_id = SW'(j);
      end
    end
    if (any) gnt[gnt_id] = 1'b1;
  end
endmodule

// File: rtl/mt_sched.sv
module mt_sched
  import mt_pkg::*;
#(
  parameter int NT = 8,
  parameter int AW = 16,
  parameter int LW = 8,
  parameter int TW = 4,
  localparam int SW = $clog2(NT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_slot,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_stride,
  input  logic [LW-1:0] cfg_len,
  input  logic [1:0]    cfg_prio,
  input  logic [TW-1:0] cfg_tag,
  input  logic          trig_valid,
  input  logic [TW-1:0] trig_tag,
  input  logic [NT-1:0] in_avail,
  input  logic [NT-1:0] out_room,
  output logic          iss_valid,
  output logic [SW-1:0] iss_slot,
  output logic [LW-1:0] iss_idx,
  output logic [AW-1:0] iss_addr,
  output logic          iss_last
);
  logic [NT-1:0]        run_vec, elig, gnt, last_vec;
  logic [NT*PRIO_W-1:0] prio_flat;
  logic [NT*AW-1:0]     addr_flat;
  logic [NT*LW-1:0]     idx_flat;
  logic                 any;
  logic [SW-1:0]        gnt_id, rr_last;

  for (genvar g = 0; g < NT; g++) begin : g_slot
    mt_slot #(.AW(AW), .LW(LW), .TW(TW)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .cfg_hit    (cfg_we && cfg_slot == SW'(g)),
      .cfg_base   (cfg_base),
      .cfg_stride (cfg_stride),
      .cfg_len    (cfg_len),
      .cfg_prio   (cfg_prio),
      .cfg_tag    (cfg_tag),
      .trig_valid (trig_valid),
      .trig_tag   (trig_tag),
      .issue_sel  (gnt[g]),
      .running    (run_vec[g]),
      .prio       (prio_flat[g*PRIO_W +: PRIO_W]),
      .cur_addr   (addr_flat[g*AW +: AW]),
      .cur_idx    (idx_flat[g*LW +: LW]),
      .is_last    (last_vec[g])
    );
  end

  assign elig = run_vec & in_avail & out_room;

  mt_arbiter #(.NT(NT)) u_arb (
    .elig      (elig),
    .prio_flat (prio_flat),
    .rr_last   (rr_last),
    .gnt       (gnt),
    .gnt_id    (gnt_id),
    .any       (any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid <= 1'b0;
      iss_slot  <= '0;
      iss_idx   <= '0;
      iss_addr  <= '0;
      iss_last  <= 1'b0;
      rr_last   <= SW'(NT - 1);
    end else begin
      iss_valid <= any;
      if (any) begin
        iss_slot <= gnt_id;
        iss_idx  <= idx_flat[gnt_id*LW +: LW];
        iss_addr <= addr_flat[gnt_id*AW +: AW];
        iss_last <= last_vec[gnt_id];
        rr_last  <= gnt_id;
      end else begin
        iss_last <= 1'b0;
      end
    end
  end

  // R5
  single_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  // R4
  work_conserve_chk: assert property (@(posedge clk) disable iff (rst)
    (|elig) |-> any);

  // R9
  quiet_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(run_vec & in_avail & out_room)) |=> !iss_valid);

  // R8
  last_frees_chk: assert property (@(posedge clk) disable iff (rst)
    (any && last_vec[gnt_id]) |=> !run_vec[$past(gnt_id)]);
endmodule

// File: tb/mt_sched_bench.sv
module mt_sched_bench;
  localparam int NT = 8, AW = 16, LW = 8, TW = 4, SW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, trig_valid = 0;
  logic [SW-1:0] cfg_slot = '0;
  logic [AW-1:0] cfg_base = '0, cfg_stride = '0;
  logic [LW-1:0] cfg_len = '0;
  logic [1:0]    cfg_prio = '0;
  logic [TW-1:0] cfg_tag = '0, trig_tag = '0;
  logic [NT-1:0] in_avail = '0, out_room = '0;
  logic          iss_valid, iss_last;
  logic [SW-1:0] iss_slot;
  logic [LW-1:0] iss_idx;
  logic [AW-1:0] iss_addr;

  always #5 clk = ~clk;

  mt_sched #(.NT(NT), .AW(AW), .LW(LW), .TW(TW)) u_mt_sched (.*);

  int n_chk = 0, n_bad = 0;
  // reference model: 0 free, 1 armed, 2 running
  int m_st[NT];
  logic [AW-1:0] m_addr[NT], m_stride[NT];
  logic [LW-1:0] m_idx[NT], m_len[NT];
  logic [1:0]    m_prio[NT];
  logic [TW-1:0] m_tag[NT];
  int m_rr;
  logic e_valid, e_last;
  int e_slot;
  logic [LW-1:0] e_idx;
  logic [AW-1:0] e_addr;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NT; i++) begin
      m_st[i] = 0; m_idx[i] = '0; m_addr[i] = '0;
    end
    m_rr = NT - 1;
    e_valid = 0;
  endtask

  task automatic model_step();
    int topp, win;
    topp = -1; win = -1;
    for (int i = 0; i < NT; i++)
      if (m_st[i] == 2 && in_avail[i] && out_room[i] && int'(m_prio[i]) > topp) topp = m_prio[i];
    for (int k = 1; k <= NT; k++) begin
      int j;
      j = (m_rr + k) % NT;
      if (win < 0 && m_st[j] == 2 && in_avail[j] && out_room[j] && int'(m_prio[j]) == topp) win = j;
    end
    e_valid = (win >= 0);
    if (win >= 0) begin
      e_slot = win; e_idx = m_idx[win]; e_addr = m_addr[win];
      e_last = (m_idx[win] == m_len[win] - 1);
      m_rr = win;
    end
    for (int i = 0; i < NT; i++) begin
      if (m_st[i] == 2 && i == win) begin
        if (e_last) m_st[i] = 0;
        else begin m_idx[i] = m_idx[i] + 1; m_addr[i] = m_addr[i] + m_stride[i]; end
      end else if (m_st[i] == 0 && cfg_we && int'(cfg_slot) == i && cfg_len != 0) begin
        m_st[i] = 1; m_addr[i] = cfg_base; m_stride[i] = cfg_stride; m_len[i] = cfg_len;
        m_prio[i] = cfg_prio; m_tag[i] = cfg_tag; m_idx[i] = '0;
      end else if (m_st[i] == 1 && trig_valid && trig_tag == m_tag[i]) begin
        m_st[i] = 2;
      end
    end
  endtask

  task automatic compare();
    chk(iss_valid == e_valid, "R2/R3/R4/R9 valid", iss_valid, e_valid);
    if (e_valid && iss_valid) begin
      chk(iss_slot == e_slot, "R5/R6 slot", iss_slot, e_slot);
      chk(iss_idx == e_idx, "R7 index", iss_idx, e_idx);
      chk(iss_addr == e_addr, "R7 address", iss_addr, e_addr);
      chk(iss_last == e_last, "R8 last", iss_last, e_last);
    end
  endtask

  // inputs were set after a falling edge; step model, cross the edge, compare
  task automatic tick();
    model_step();
    @(negedge clk);
    compare();
    cfg_we = 0; trig_valid = 0;
  endtask

  task automatic wr(input int s, input int base, input int str, input int len, input int pr, input int tg);
    cfg_we = 1; cfg_slot = SW'(s); cfg_base = AW'(base); cfg_stride = AW'(str);
    cfg_len = LW'(len); cfg_prio = 2'(pr); cfg_tag = TW'(tg);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    chk(iss_valid == 0, "R1 reset valid", iss_valid, 0);
    in_avail = '1; out_room = '1;
    // R5: equal tag, higher priority slot 5 goes first
    wr(2, 100, 4, 3, 1, 7); tick();
    wr(5, 200, 2, 2, 3, 7); tick();
    trig_valid = 1; trig_tag = 7; tick();
    repeat (6) tick();
    // R6: three equal-priority threads rotate
    wr(0, 10, 1, 3, 2, 1); tick();
    wr(3, 30, 1, 3, 2, 1); tick();
    wr(6, 60, 1, 3, 2, 1); tick();
    trig_valid = 1; trig_tag = 1; tick();
    repeat (10) tick();
    // R2/R8: write on the final-issue cycle is ignored, next cycle accepted
    wr(4, 500, 3, 2, 0, 2); tick();
    trig_valid = 1; trig_tag = 2; tick();
    tick();                                  // element 0 decided
    wr(4, 900, 1, 1, 0, 3); tick();          // final element decided: write dropped
    chk(iss_last == 1, "R8 final flagged", iss_last, 1);
    wr(4, 900, 1, 1, 0, 3); tick();          // accepted now
    trig_valid = 1; trig_tag = 3; tick();
    tick();
    chk(iss_valid && iss_addr == 900, "R2 fresh descriptor", iss_addr, 900);
    // R4/R9: readiness gating
    wr(1, 70, 5, 4, 1, 4); tick();
    trig_valid = 1; trig_tag = 4; in_avail = '0; tick();
    repeat (3) tick();
    in_avail = '1; out_room = '0; repeat (2) tick();
    out_room = '1; repeat (6) tick();
    // random phase
    for (int c = 0; c < 4000; c++) begin
      in_avail = NT'($urandom) | NT'($urandom);
      out_room = NT'($urandom) | NT'($urandom);
      if ($urandom_range(0, 2) == 0)
        wr($urandom_range(0, NT-1), $urandom, $urandom_range(0, 9), $urandom_range(0, 5),
           $urandom_range(0, 3), $urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) begin
        trig_valid = 1; trig_tag = TW'($urandom_range(0, 3));
      end
      tick();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule